// File: doc/BRIEF.md
# Fully Associative Address Translation Cache

This block caches recent virtual-to-physical page mappings so that most address translations finish without a walk of the in-memory page table. A lookup presents a virtual page number and an in-page offset. In the same cycle, the block compares that page number against every stored entry at once. It returns a hit flag, the cached frame number, the composed physical address and two permission flags: read-only and modified.

When a lookup misses, an external page table walker fetches the mapping and installs it through the fill port. A fill goes to one of three places, in this order of preference:
- the entry that already holds the same page, if there is one;
- otherwise the lowest-numbered empty entry;
- otherwise the entry used least recently.

Both lookup hits and fills count as uses. A single flush pulse empties the cache, for example on a context switch.

Each entry tracks its recency as a rank: 0 means most recent and N_ENTRIES-1 means least recent. The ranks always form a permutation of those values.

Top module: `tlb_fa`

## Requirements
- R1: A lookup with `lk_valid` high compares `lk_vpn` against every valid entry in parallel. When a valid entry holds that page, `lk_hit` is 1 and `lk_pfn` carries its frame number in the same cycle, with no clock edge in between.
- R2: On a hit, `lk_paddr` equals the frame number in its upper PFN_W bits and `lk_offset` in its lower OFF_W bits.
- R3: When `lk_valid` is low, or no valid entry holds `lk_vpn`, the block reports a miss: `lk_hit`, `lk_pfn`, `lk_paddr`, `lk_ro` and `lk_dirty` are all 0.
- R4: A fill (`fill_en` high, `flush` low) is visible to lookups from the cycle after the clock edge that captures it.
- R5: A fill of a page that is not present goes to the lowest-indexed invalid entry whenever one exists. No valid mapping is evicted while the cache has a free entry.
- R6: A fill of a page that is not present, with all entries valid, replaces the least recently used entry. Recency ranks always stay a permutation of 0..N_ENTRIES-1.
- R7: A lookup hit, and a fill, each make the touched entry the most recently used. When a hit and a fill happen in the same cycle, the hit is applied first and the filled entry ends most recent.
- R8: A fill of a page that is already present overwrites that entry's frame and flags. It creates no second copy and evicts nothing else.
- R9: `flush` clears every valid bit at the next clock edge. A lookup in a flush cycle reports a miss, and a fill in a flush cycle is dropped.
- R10: At no time does more than one entry match the looked-up page.
- R11: On a hit, `lk_ro` and `lk_dirty` return the read-only and modified flags stored by the most recent fill of that page.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset; empties the cache |
| flush | input | 1 | Invalidate all entries at the next edge |
| lk_valid | input | 1 | Lookup request qualifier |
| lk_vpn | input | VPN_W | Virtual page number to translate |
| lk_offset | input | OFF_W | In-page offset passed into the physical address |
| lk_hit | output | 1 | Lookup found a valid mapping |
| lk_pfn | output | PFN_W | Frame number of the hit entry, 0 on miss |
| lk_paddr | output | PFN_W+OFF_W | Frame number joined with offset, 0 on miss |
| lk_ro | output | 1 | Read-only flag of the hit entry |
| lk_dirty | output | 1 | Modified flag of the hit entry |
| fill_en | input | 1 | Install a mapping at the next edge |
| fill_vpn | input | VPN_W | Page number of the new mapping |
| fill_pfn | input | PFN_W | Frame number of the new mapping |
| fill_ro | input | 1 | Read-only flag of the new mapping |
| fill_dirty | input | 1 | Modified flag of the new mapping |

## Verification
The bench builds the cache with 4 entries, 6-bit page and frame numbers and a 4-bit offset. With those values, all 64 page numbers can be probed after every operation. Fills draw from only 16 pages, so the cache fills quickly and the following states occur again and again:
- evictions from a full cache;
- fills of a page already present;
- a hit and a fill in the same cycle;
- flushes in the middle of a sequence.

Each probe is compared against a recency model kept in the bench. The bench's model therefore checks every victim choice and every overwrite on the next sweep.

// File: rtl/tlb_pkg.sv
package tlb_pkg;

    // Where a fill lands
    typedef enum logic [1:0] {
        FILL_REUSE = 2'd0,   // entry already holds the page
        FILL_FREE  = 2'd1,   // lowest invalid entry
        FILL_EVICT = 2'd2    // least recently used entry
    } fill_src_e;

endpackage

// File: rtl/tlb_match.sv
module tlb_match #(
    parameter  int N_ENTRIES = 8,
    parameter  int VPN_W     = 20,
    localparam int IDX_W     = $clog2(N_ENTRIES)
) (
    input  logic [N_ENTRIES-1:0]       vld,
    input  logic [N_ENTRIES*VPN_W-1:0] tags,
    input  logic [VPN_W-1:0]           key,
    output logic [N_ENTRIES-1:0]       match_vec,
    output logic [IDX_W-1:0]           match_idx
);

    // One comparator per entry, all evaluated at once
    genvar g;
    generate
        for (g = 0; g < N_ENTRIES; g++) begin : g_cmp
            assign match_vec[g] = vld[g] && (tags[g*VPN_W +: VPN_W] == key);
        end
    endgenerate

    // OR-encoder: correct because at most one bit is set
    always_comb begin
        match_idx = '0;
        for (int i = 0; i < N_ENTRIES; i++) begin
            if (match_vec[i]) match_idx = match_idx | IDX_W'(i);
        end
    end

endmodule

// File: rtl/tlb_victim.sv
module tlb_victim
    import tlb_pkg::*;
#(
    parameter  int N_ENTRIES = 8,
    localparam int IDX_W     = $clog2(N_ENTRIES)
) (
    input  logic [N_ENTRIES-1:0]       vld,
    input  logic                       reuse_hit,
    input  logic [IDX_W-1:0]           reuse_idx,
    input  logic [N_ENTRIES*IDX_W-1:0] ranks,
    output logic [IDX_W-1:0]           tgt_idx,
    output fill_src_e                  tgt_src
);

    localparam logic [IDX_W-1:0] OLDEST = IDX_W'(N_ENTRIES - 1);

    logic             free_found;
    logic [IDX_W-1:0] free_idx;
    logic [IDX_W-1:0] lru_idx;

    always_comb begin
        // Scan downward so the lowest invalid index wins
        free_found = 1'b0;
        free_idx   = '0;
        for (int i = N_ENTRIES - 1; i >= 0; i--) begin
            if (!vld[i]) begin
                free_found = 1'b1;
                free_idx   = IDX_W'(i);
            end
        end

        // Exactly one entry carries the oldest rank
        lru_idx = '0;
        for (int i = 0; i < N_ENTRIES; i++) begin
            if (ranks[i*IDX_W +: IDX_W] == OLDEST) lru_idx = IDX_W'(i);
        end

        if (reuse_hit) begin
            tgt_idx = reuse_idx;
            tgt_src = FILL_REUSE;
        end else if (free_found) begin
            tgt_idx = free_idx;
            tgt_src = FILL_FREE;
        end else begin
            tgt_idx = lru_idx;
            tgt_src = FILL_EVICT;
        end
    end

endmodule

// File: rtl/tlb_fa.sv
module tlb_fa
    import tlb_pkg::*;
#(
    parameter  int N_ENTRIES = 8,
    parameter  int VPN_W     = 20,
    parameter  int PFN_W     = 20,
    parameter  int OFF_W     = 12,
    localparam int IDX_W     = $clog2(N_ENTRIES),
    localparam int PA_W      = PFN_W + OFF_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             flush,
    input  logic             lk_valid,
    input  logic [VPN_W-1:0] lk_vpn,
    input  logic [OFF_W-1:0] lk_offset,
    output logic             lk_hit,
    output logic [PFN_W-1:0] lk_pfn,
    output logic [PA_W-1:0]  lk_paddr,
    output logic             lk_ro,
    output logic             lk_dirty,
    input  logic             fill_en,
    input  logic [VPN_W-1:0] fill_vpn,
    input  logic [PFN_W-1:0] fill_pfn,
    input  logic             fill_ro,
    input  logic             fill_dirty
);

    typedef struct packed {
        logic [N_ENTRIES-1:0]            vld;
        logic [N_ENTRIES-1:0][VPN_W-1:0] tag;
        logic [N_ENTRIES-1:0][PFN_W-1:0] pfn;
        logic [N_ENTRIES-1:0]            ro;
        logic [N_ENTRIES-1:0]            dirty;
        logic [N_ENTRIES-1:0][IDX_W-1:0] rank;   // 0 = most recent
    } state_t;

    function automatic state_t init_state();
        state_t s;
        s = '0;
        for (int i = 0; i < N_ENTRIES; i++) s.rank[i] = IDX_W'(i);
        return s;
    endfunction

    state_t st_q, st_d;

    logic [N_ENTRIES-1:0] lk_vec;
    logic [IDX_W-1:0]     lk_idx;
    logic [N_ENTRIES-1:0] fl_vec;
    logic [IDX_W-1:0]     fl_idx;
    logic [IDX_W-1:0]     fill_idx;
    fill_src_e            fill_src;
    logic                 fill_do;
    logic [IDX_W-1:0]     rk_hit;
    logic [IDX_W-1:0]     rk_fill;

    // Lookup comparators
    tlb_match #(.N_ENTRIES(N_ENTRIES), .VPN_W(VPN_W)) u_lk_match (
        .vld       (st_q.vld),
        .tags      (st_q.tag),
        .key       (lk_vpn),
        .match_vec (lk_vec),
        .match_idx (lk_idx)
    );

    // Fill comparators: detect a page already present
    tlb_match #(.N_ENTRIES(N_ENTRIES), .VPN_W(VPN_W)) u_fl_match (
        .vld       (st_q.vld),
        .tags      (st_q.tag),
        .key       (fill_vpn),
        .match_vec (fl_vec),
        .match_idx (fl_idx)
    );

    tlb_victim #(.N_ENTRIES(N_ENTRIES)) u_victim (
        .vld       (st_q.vld),
        .reuse_hit (|fl_vec),
        .reuse_idx (fl_idx),
        .ranks     (st_q.rank),
        .tgt_idx   (fill_idx),
        .tgt_src   (fill_src)
    );

    // Lookup outputs, combinational from registered state
    always_comb begin
        lk_hit   = lk_valid && !flush && (|lk_vec);
        lk_pfn   = '0;
        lk_paddr = '0;
        lk_ro    = 1'b0;
        lk_dirty = 1'b0;
        if (lk_hit) begin
            lk_pfn   = st_q.pfn[lk_idx];
            lk_paddr = {st_q.pfn[lk_idx], lk_offset};
            lk_ro    = st_q.ro[lk_idx];
            lk_dirty = st_q.dirty[lk_idx];
        end
    end

    assign fill_do = fill_en && !flush;

    // Next-state logic
    always_comb begin
        st_d    = st_q;
        rk_hit  = '0;
        rk_fill = '0;

        // Hit touch first
        if (lk_hit) begin
            rk_hit = st_d.rank[lk_idx];
            for (int i = 0; i < N_ENTRIES; i++) begin
                if (st_d.rank[i] < rk_hit) st_d.rank[i] = st_d.rank[i] + 1'b1;
            end
            st_d.rank[lk_idx] = '0;
        end

        // Then the fill, so it ends most recent
        if (fill_do) begin
            st_d.vld[fill_idx]   = 1'b1;
            if (fill_src != FILL_REUSE) st_d.tag[fill_idx] = fill_vpn;
            st_d.pfn[fill_idx]   = fill_pfn;
            st_d.ro[fill_idx]    = fill_ro;
            st_d.dirty[fill_idx] = fill_dirty;
            rk_fill = st_d.rank[fill_idx];
            for (int i = 0; i < N_ENTRIES; i++) begin
                if (st_d.rank[i] < rk_fill) st_d.rank[i] = st_d.rank[i] + 1'b1;
            end
            st_d.rank[fill_idx] = '0;
        end

        if (flush) st_d.vld = '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= init_state();
        else        st_q <= st_d;
    end

endmodule

// File: rtl/tlb_fa_chk.sv
module tlb_fa_chk
    import tlb_pkg::*;
#(
    parameter int N_ENTRIES = 8,
    parameter int VPN_W     = 20,
    parameter int IDX_W     = 3
) (
    input logic                       clk,
    input logic                       rst_n,
    input logic                       flush,
    input logic                       fill_en,
    input logic [VPN_W-1:0]           fill_vpn,
    input fill_src_e                  fill_src,
    input logic [N_ENTRIES-1:0]       lk_vec,
    input logic [N_ENTRIES-1:0]       vld,
    input logic [N_ENTRIES*VPN_W-1:0] tags,
    input logic [N_ENTRIES*IDX_W-1:0] ranks
);

    logic             prev_fill;
    logic             prev_flush;
    logic [VPN_W-1:0] prev_vpn;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            prev_fill  <= 1'b0;
            prev_flush <= 1'b0;
            prev_vpn   <= '0;
        end else begin
            prev_fill  <= fill_en && !flush;
            prev_flush <= flush;
            prev_vpn   <= fill_vpn;
        end
    end

    logic [N_ENTRIES-1:0] same_tag;
    logic                 mru_ok;
    logic                 perm_ok;

    always_comb begin
        mru_ok = 1'b0;
        for (int i = 0; i < N_ENTRIES; i++) begin
            same_tag[i] = vld[i] && (tags[i*VPN_W +: VPN_W] == prev_vpn);
            if (same_tag[i] && (ranks[i*IDX_W +: IDX_W] == '0)) mru_ok = 1'b1;
        end
    end

    always_comb begin : perm_blk
        int cnt;
        perm_ok = 1'b1;
        for (int v = 0; v < N_ENTRIES; v++) begin
            cnt = 0;
            for (int i = 0; i < N_ENTRIES; i++) begin
                if (ranks[i*IDX_W +: IDX_W] == IDX_W'(v)) cnt++;
            end
            if (cnt != 1) perm_ok = 1'b0;
        end
    end

    a_r10_single_match: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(lk_vec));

    a_r9_flush_empties: assert property (@(posedge clk) disable iff (!rst_n)
        prev_flush |-> (vld == '0));

    a_r8_no_duplicate: assert property (@(posedge clk) disable iff (!rst_n)
        prev_fill |-> ($countones(same_tag) == 1));

    a_r7_fill_is_mru: assert property (@(posedge clk) disable iff (!rst_n)
        prev_fill |-> mru_ok);

    a_r6_rank_permutation: assert property (@(posedge clk) disable iff (!rst_n)
        perm_ok);

    a_r5_evict_only_when_full: assert property (@(posedge clk) disable iff (!rst_n)
        (fill_en && !flush && (fill_src == FILL_EVICT)) |-> (&vld));

endmodule

bind tlb_fa tlb_fa_chk #(
    .N_ENTRIES (N_ENTRIES),
    .VPN_W     (VPN_W),
    .IDX_W     (IDX_W)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .flush    (flush),
    .fill_en  (fill_en),
    .fill_vpn (fill_vpn),
    .fill_src (fill_src),
    .lk_vec   (lk_vec),
    .vld      (st_q.vld),
    .tags     (st_q.tag),
    .ranks    (st_q.rank)
);

// File: tb/tb_tlb_fa.sv
module tb_tlb_fa;

    localparam int CLK_PERIOD = 10;
    localparam int N  = 4;
    localparam int VW = 6;
    localparam int PW = 6;
    localparam int OW = 4;
    localparam int NPAGES = 1 << VW;

    logic clk = 1'b0;
    logic clk_run = 1'b1;
    logic rst_n = 1'b0;
    logic flush = 1'b0;
    logic lk_valid = 1'b0;
    logic [VW-1:0] lk_vpn = '0;
    logic [OW-1:0] lk_offset = '0;
    logic lk_hit, lk_ro, lk_dirty;
    logic [PW-1:0] lk_pfn;
    logic [PW+OW-1:0] lk_paddr;
    logic fill_en = 1'b0;
    logic [VW-1:0] fill_vpn = '0;
    logic [PW-1:0] fill_pfn = '0;
    logic fill_ro = 1'b0;
    logic fill_dirty = 1'b0;

    int n_chk = 0;
    int n_err = 0;

    tlb_fa #(.N_ENTRIES(N), .VPN_W(VW), .PFN_W(PW), .OFF_W(OW)) dut (
        .clk(clk), .rst_n(rst_n), .flush(flush),
        .lk_valid(lk_valid), .lk_vpn(lk_vpn), .lk_offset(lk_offset),
        .lk_hit(lk_hit), .lk_pfn(lk_pfn), .lk_paddr(lk_paddr),
        .lk_ro(lk_ro), .lk_dirty(lk_dirty),
        .fill_en(fill_en), .fill_vpn(fill_vpn), .fill_pfn(fill_pfn),
        .fill_ro(fill_ro), .fill_dirty(fill_dirty)
    );

    always begin
        #(CLK_PERIOD / 2);
        if (clk_run) clk = ~clk;
    end

    // Reference model
    bit          m_vld  [N];
    logic [VW-1:0] m_tag [N];
    logic [PW-1:0] m_pfn [N];
    bit          m_ro   [N];
    bit          m_dy   [N];
    int          m_rank [N];

    function automatic int m_find(logic [VW-1:0] v);
        for (int i = 0; i < N; i++) if (m_vld[i] && m_tag[i] == v) return i;
        return -1;
    endfunction

    function automatic void m_touch(int k);
        int rk = m_rank[k];
        for (int i = 0; i < N; i++) if (m_rank[i] < rk) m_rank[i]++;
        m_rank[k] = 0;
    endfunction

    function automatic int m_target(logic [VW-1:0] v);
        int f = m_find(v);
        if (f >= 0) return f;
        for (int i = 0; i < N; i++) if (!m_vld[i]) return i;
        for (int i = 0; i < N; i++) if (m_rank[i] == N - 1) return i;
        return 0;
    endfunction

    task automatic check(input bit ok, input string req, input string what,
                         input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // Probe every page with the clock held low
    task automatic sweep(input string req);
        clk_run = 1'b0;
        for (int v = 0; v < NPAGES; v++) begin
            logic [18:0] exp_w, act_w;
            int k;
            lk_vpn    = VW'(v);
            lk_offset = OW'(v * 3 + 1);
            lk_valid  = 1'b1;
            #1;
            k = m_find(VW'(v));
            if (k >= 0)
                exp_w = {1'b1, m_ro[k], m_dy[k], m_pfn[k], m_pfn[k], lk_offset};
            else
                exp_w = '0;
            act_w = {lk_hit, lk_ro, lk_dirty, lk_pfn, lk_paddr};
            check(act_w == exp_w, req, $sformatf("page %0d", v), 64'(act_w), 64'(exp_w));
        end
        lk_valid = 1'b0;
        #1;
        clk_run = 1'b1;
    endtask

    // One clock of activity, then a full sweep
    task automatic op(input bit do_lk, input logic [VW-1:0] lv,
                      input bit do_fill, input logic [VW-1:0] fv, input logic [PW-1:0] fp,
                      input bit fro, input bit fdy, input bit do_flush, input string req);
        int tgt, h;
        lk_valid = do_lk; lk_vpn = lv; lk_offset = '0;
        fill_en = do_fill; fill_vpn = fv; fill_pfn = fp; fill_ro = fro; fill_dirty = fdy;
        flush = do_flush;
        #1;
        if (do_flush && do_lk)
            check(lk_hit == 1'b0, "R9", "lookup during flush", 64'(lk_hit), 64'd0);
        tgt = m_target(fv);
        h = m_find(lv);
        @(posedge clk);
        #1;
        lk_valid = 1'b0; fill_en = 1'b0; flush = 1'b0;
        if (do_flush) begin
            for (int i = 0; i < N; i++) m_vld[i] = 1'b0;
        end else begin
            if (do_lk && h >= 0) m_touch(h);
            if (do_fill) begin
                m_vld[tgt] = 1'b1; m_tag[tgt] = fv; m_pfn[tgt] = fp;
                m_ro[tgt] = fro; m_dy[tgt] = fdy;
                m_touch(tgt);
            end
        end
        @(negedge clk);
        sweep(req);
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        n_chk++; n_err++;
        $display("FAIL watchdog: actual=expired expected=done");
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        int unsigned seed = 32'h1234_5678;
        for (int i = 0; i < N; i++) begin
            m_vld[i] = 0; m_tag[i] = '0; m_pfn[i] = '0; m_ro[i] = 0; m_dy[i] = 0; m_rank[i] = i;
        end
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        sweep("R3 reset");

        // R4 R5 R1 R2 R11: fill the four entries
        op(0, 0, 1, 6'd10, 6'd33, 1, 0, 0, "R4/R5/R1/R2/R11");
        op(0, 0, 1, 6'd11, 6'd34, 0, 1, 0, "R4/R5");
        op(0, 0, 1, 6'd12, 6'd35, 1, 1, 0, "R4/R5");
        op(0, 0, 1, 6'd13, 6'd36, 0, 0, 0, "R4/R5");
        // R3: lookup with qualifier low on a present page
        lk_valid = 1'b0; lk_vpn = 6'd10; #1;
        check(lk_hit == 1'b0 && lk_pfn == '0, "R3", "qualifier low", 64'(lk_hit), 64'd0);
        // R7 then R6: touch page 10, new page evicts page 11
        op(1, 6'd10, 0, 0, 0, 0, 0, 0, "R7 hit touch");
        op(0, 0, 1, 6'd20, 6'd40, 0, 0, 0, "R6 evict LRU");
        lk_valid = 1'b1; lk_vpn = 6'd11; #1;
        check(lk_hit == 1'b0, "R6", "page 11 evicted", 64'(lk_hit), 64'd0);
        lk_vpn = 6'd10; #1;
        check(lk_hit == 1'b1, "R7", "page 10 kept", 64'(lk_hit), 64'd1);
        lk_valid = 1'b0;
        // R8: refill page 12 with new frame
        op(0, 0, 1, 6'd12, 6'd50, 0, 1, 0, "R8 overwrite");
        // R7: hit and fill in the same cycle
        op(1, 6'd13, 1, 6'd21, 6'd41, 1, 0, 0, "R7 hit plus fill");
        // R9: flush with a lookup and a fill in the same cycle
        op(1, 6'd21, 1, 6'd22, 6'd42, 0, 0, 1, "R9 flush");
        // R5 after flush: four fills, none evicts another
        for (int i = 0; i < N; i++)
            op(0, 0, 1, VW'(30 + i), PW'(i + 1), 0, 0, 0, "R5 refill");

        // Random mix
        for (int s = 0; s < 300; s++) begin
            int r;
            seed = seed * 1664525 + 1013904223;
            r = int'(seed >> 8);
            case (r % 8)
                0, 1, 2, 3: op(0, 0, 1, VW'((r >> 4) % 16), PW'(r >> 10), r[20], r[21], 0,
                               "R4/R5/R6/R8/R11 random fill");
                4, 5: op(1, VW'((r >> 4) % 16), 0, 0, 0, 0, 0, 0, "R1/R7 random hit");
                6: op(1, VW'((r >> 4) % 16), 1, VW'((r >> 12) % 16), PW'(r >> 16), r[22], r[23],
                      0, "R7 random hit plus fill");
                default: op(1, VW'((r >> 4) % 16), r[9], VW'((r >> 12) % 16), PW'(r >> 16), 0, 0,
                            (r % 5) == 0, "R9/R2 random");
            endcase
        end

        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

endmodule